// File: doc/BRIEF.md
# Protection Region Bounds Decoder

This block turns the per-entry settings of a physical memory protection unit into explicit, inclusive byte ranges. For each entry it takes an 8-bit configuration byte and a word address register, which holds a physical byte address shifted right by two. It produces a first-byte and last-byte address for that entry. A permission checker further down the pipeline then only needs two magnitude comparisons per entry. The block also reports how many entries are switched on.

Four match modes are decoded from configuration bits [4:3]:
- **Disabled**: the entry spans the whole space and is not counted.
- **Top-of-range**: the range runs from the neighbour's address up to this entry's address. An inverted range collapses to zero.
- **4-byte word**: the range covers the single word the address names.
- **Naturally aligned power of two**: the size comes from the run of trailing ones in the address.

All outputs are registered. Every entry is recomputed on every clock from the current register-file contents, so a change to one address also refreshes the top-of-range lower bound of the next entry at the same edge.

Top module: `pmp_bounds_decoder`

## Requirements
- R1: An entry whose mode field (configuration bits [4:3]) is 0 (disabled) reports first byte 0 and last byte all-ones.
- R2: In mode 1 (top-of-range), the first byte is the previous entry's address register shifted left by two, and the last byte is this entry's address shifted left by two, minus one, modulo the byte-address width. Entry 0 uses 0 as its previous address.
- R3: In mode 1, when the computed first byte exceeds the computed last byte, both bounds are reported as 0.
- R4: In mode 2 (4-byte word), the first byte is the address shifted left by two and the last byte is that value plus 3.
- R5: In mode 3 (power-of-two), an address ending in 0 gives an aligned 8-byte range, and each further trailing one doubles the size. The range is aligned to its own size, and a size reaching the whole byte space gives first byte 0 and last byte all-ones.
- R6: The active count equals the number of entries whose mode field is not 0.
- R7: Outputs reflect the inputs present at the previous rising clock edge. A change to entry i's address alone updates entry i+1's top-of-range first byte at that same edge.
- R8: While reset is high, and after it until the first decode, every entry reports first byte 0 and last byte all-ones, and the active count is 0.
- R9: Configuration bits other than [4:3] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_in | input | NUM_ENT*8 | Configuration bytes, entry i at bits [8i+7:8i] |
| addr_in | input | NUM_ENT*ADDR_W | Address registers (byte address >> 2), entry i at slice i |
| lo_out | output | NUM_ENT*(ADDR_W+2) | Inclusive first byte per entry |
| hi_out | output | NUM_ENT*(ADDR_W+2) | Inclusive last byte per entry |
| active_cnt | output | $clog2(NUM_ENT+1) | Number of entries not disabled |

## Verification
On every cycle, the assertions check the shape of each registered range against the mode that was present one edge earlier:
- a disabled entry spans the whole space;
- a word entry is exactly four bytes;
- a top-of-range entry is never inverted;
- a power-of-two entry has a power-of-two size and is aligned to it;
- the active count never exceeds the entry count.

The exact bound values only come from the bench's sweep, which covers every mode and address pair of the first two entries against an arithmetic model. The bench also shows that the neighbour's bound follows an address change at the following edge, and that configuration bits outside the mode field are ignored.

// File: rtl/pmp_bounds_pkg.sv
package pmp_bounds_pkg;
  localparam int CFG_W    = 8;
  localparam int MODE_LSB = 3;
  localparam int MODE_W   = 2;

  typedef enum logic [MODE_W-1:0] {
    MATCH_OFF   = 2'd0,
    MATCH_TOR   = 2'd1,
    MATCH_WORD  = 2'd2,
    MATCH_POW2  = 2'd3
  } match_mode_e;
endpackage

// File: rtl/pmp_pow2_span.sv
// Aligned power-of-two range from a word address whose trailing ones encode the size.
module pmp_pow2_span #(
  parameter int ADDR_W = 30,
  localparam int BW    = ADDR_W + 2
) (
  input  logic [ADDR_W-1:0] word_addr,
  output logic [BW-1:0]     span_lo,
  output logic [BW-1:0]     span_hi
);
  logic [BW-1:0] filled;
  logic [BW-1:0] filled_inc;

  always_comb begin
    filled     = {word_addr, 2'b11};
    filled_inc = filled + BW'(1);
    span_lo    = filled & filled_inc;
    span_hi    = filled | filled_inc;
  end
endmodule

// File: rtl/pmp_entry_bounds.sv
// Combinational bound selection for one entry.
module pmp_entry_bounds
  import pmp_bounds_pkg::*;
#(
  parameter int ADDR_W = 30,
  localparam int BW    = ADDR_W + 2
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] prev_addr,
  output logic [BW-1:0]     lo,
  output logic [BW-1:0]     hi,
  output logic              active
);
  logic [BW-1:0] p2_lo, p2_hi;
  logic [BW-1:0] tor_lo, tor_hi;
  logic [BW-1:0] word_lo;

  pmp_pow2_span #(.ADDR_W(ADDR_W)) u_pow2 (
    .word_addr (own_addr),
    .span_lo   (p2_lo),
    .span_hi   (p2_hi)
  );

  always_comb begin
    tor_lo  = {prev_addr, 2'b00};
    tor_hi  = {own_addr, 2'b00} - BW'(1);
    word_lo = {own_addr, 2'b00};
    active  = (mode != MATCH_OFF);
    unique case (match_mode_e'(mode))
      MATCH_OFF: begin
        lo = '0;
        hi = '1;
      end
      MATCH_TOR: begin
        if (tor_lo > tor_hi) begin
          lo = '0;
          hi = '0;
        end else begin
          lo = tor_lo;
          hi = tor_hi;
        end
      end
      MATCH_WORD: begin
        lo = word_lo;
        hi = word_lo | BW'(3);
      end
      default: begin
        lo = p2_lo;
        hi = p2_hi;
      end
    endcase
  end
endmodule

// File: rtl/pmp_active_count.sv
module pmp_active_count #(
  parameter int NUM_ENT = 8,
  localparam int CW     = $clog2(NUM_ENT + 1)
) (
  input  logic [NUM_ENT-1:0] active,
  output logic [CW-1:0]      count
);
  always_comb begin
    count = '0;
    for (int k = 0; k < NUM_ENT; k++) begin
      count = count + CW'(active[k]);
    end
  end
endmodule

// File: rtl/pmp_bounds_decoder.sv
module pmp_bounds_decoder
  import pmp_bounds_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int ADDR_W  = 30,
  localparam int BW     = ADDR_W + 2,
  localparam int CW     = $clog2(NUM_ENT + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_ENT*CFG_W-1:0]  cfg_in,
  input  logic [NUM_ENT*ADDR_W-1:0] addr_in,
  output logic [NUM_ENT*BW-1:0]     lo_out,
  output logic [NUM_ENT*BW-1:0]     hi_out,
  output logic [CW-1:0]             active_cnt
);
  logic [MODE_W-1:0] mode_w [NUM_ENT];
  logic [BW-1:0]     lo_d   [NUM_ENT];
  logic [BW-1:0]     hi_d   [NUM_ENT];
  logic [BW-1:0]     lo_q   [NUM_ENT];
  logic [BW-1:0]     hi_q   [NUM_ENT];
  logic [NUM_ENT-1:0] active_w;
  logic [CW-1:0]     cnt_d;
  logic [CW-1:0]     cnt_q;
  logic              primed_q;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic [ADDR_W-1:0] prev_a;

    assign mode_w[i] = cfg_in[i*CFG_W + MODE_LSB +: MODE_W];

    if (i == 0) begin : g_first
      assign prev_a = '0;
    end else begin : g_rest
      assign prev_a = addr_in[(i-1)*ADDR_W +: ADDR_W];
    end

    pmp_entry_bounds #(.ADDR_W(ADDR_W)) u_ent (
      .mode      (mode_w[i]),
      .own_addr  (addr_in[i*ADDR_W +: ADDR_W]),
      .prev_addr (prev_a),
      .lo        (lo_d[i]),
      .hi        (hi_d[i]),
      .active    (active_w[i])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[i] <= '0;
        hi_q[i] <= '1;
      end else begin
        lo_q[i] <= lo_d[i];
        hi_q[i] <= hi_d[i];
      end
    end

    assign lo_out[i*BW +: BW] = lo_q[i];
    assign hi_out[i*BW +: BW] = hi_q[i];

    AST_OFF_FULL_SPAN: assert property (@(posedge clk) disable iff (rst || !primed_q)
      ($past(mode_w[i]) == MATCH_OFF) |-> (lo_q[i] == '0 && hi_q[i] == '1)); // R1
    AST_TOR_NOT_INVERTED: assert property (@(posedge clk) disable iff (rst || !primed_q)
      ($past(mode_w[i]) == MATCH_TOR) |-> (lo_q[i] <= hi_q[i])); // R3
    AST_WORD_FOUR_BYTES: assert property (@(posedge clk) disable iff (rst || !primed_q)
      ($past(mode_w[i]) == MATCH_WORD) |-> ((hi_q[i] - lo_q[i]) == BW'(3))); // R4
    AST_POW2_ALIGNED: assert property (@(posedge clk) disable iff (rst || !primed_q)
      ($past(mode_w[i]) == MATCH_POW2) |->
        ((((hi_q[i] - lo_q[i]) & (hi_q[i] - lo_q[i] + BW'(1))) == '0) &&
         ((lo_q[i] & (hi_q[i] - lo_q[i])) == '0))); // R5
  end

  pmp_active_count #(.NUM_ENT(NUM_ENT)) u_cnt (
    .active (active_w),
    .count  (cnt_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      primed_q <= 1'b1;
    end
  end

  assign active_cnt = cnt_q;

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cnt_q <= CW'(NUM_ENT))); // R6
  AST_RESET_CLEARS_COUNT: assert property (@(posedge clk)
    $past(rst) |-> (cnt_q == '0)); // R8
endmodule

// File: tb/pmp_bounds_decoder_tb.sv
`timescale 1ns/1ps
module pmp_bounds_decoder_tb;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int BW = AW + 2;
  localparam int CW = $clog2(N + 1);
  localparam int MASK = (1 << BW) - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N*8-1:0]  cfg_in = '0;
  logic [N*AW-1:0] addr_in = '0;
  logic [N*BW-1:0] lo_out, hi_out;
  logic [CW-1:0]   active_cnt;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  int md [N];
  int ad [N];

  always #10 clk = ~clk;

  pmp_bounds_decoder #(.NUM_ENT(N), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .cfg_in(cfg_in), .addr_in(addr_in),
    .lo_out(lo_out), .hi_out(hi_out), .active_cnt(active_cnt)
  );

  function automatic void model(input int m, input int a, input int p,
                                output int lo, output int hi);
    int t, size;
    case (m)
      0: begin lo = 0; hi = MASK; end
      1: begin
        lo = (p << 2) & MASK;
        hi = ((a << 2) - 1) & MASK;
        if (lo > hi) begin lo = 0; hi = 0; end
      end
      2: begin lo = (a << 2) & MASK; hi = lo + 3; end
      default: begin
        t = 0;
        while (t < AW && ((a >> t) & 1) == 1) t++;
        size = 1 << (t + 3);
        if (size > MASK) begin lo = 0; hi = MASK; end
        else begin lo = (a << 2) & ~(size - 1) & MASK; hi = lo + size - 1; end
      end
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string tag(input int m);
    case (m)
      0: return "R1";
      1: return "R2/R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // Drive entry settings; junk lands outside bits [4:3] (R9).
  task automatic apply(input int junk);
    for (int e = 0; e < N; e++) begin
      cfg_in[e*8 +: 8]   = 8'((junk + e * 53) & 8'hE7) | 8'(md[e] << 3);
      addr_in[e*AW +: AW] = AW'(ad[e]);
    end
  endtask

  task automatic check_all();
    int lo, hi, cnt;
    cnt = 0;
    for (int e = 0; e < N; e++) begin
      model(md[e], ad[e], (e == 0) ? 0 : ad[e-1], lo, hi);
      chk({tag(md[e]), " lo"}, int'(lo_out[e*BW +: BW]), lo);
      chk({tag(md[e]), " hi"}, int'(hi_out[e*BW +: BW]), hi);
      if (md[e] != 0) cnt++;
    end
    chk("R6 count", int'(active_cnt), cnt);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    int lo, hi;
    for (int e = 0; e < N; e++) begin md[e] = 3; ad[e] = e + 5; end
    apply(8'hFF);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state while reset is held, despite active inputs
    for (int e = 0; e < N; e++) begin
      chk("R8 lo", int'(lo_out[e*BW +: BW]), 0);
      chk("R8 hi", int'(hi_out[e*BW +: BW]), MASK);
    end
    chk("R8 count", int'(active_cnt), 0);
    rst = 1'b0;

    // Exhaustive sweep over modes and addresses of entries 0 and 1
    for (int m0 = 0; m0 < 4; m0++)
      for (int m1 = 0; m1 < 4; m1++)
        for (int a0 = 0; a0 < 16; a0++)
          for (int a1 = 0; a1 < 16; a1++) begin
            md[0] = m0; md[1] = m1; md[2] = (a0 + m1) % 4; md[3] = (a1 + m0) % 4;
            ad[0] = a0; ad[1] = a1; ad[2] = a0 ^ a1; ad[3] = (a1 * 3 + 1) & 15;
            @(negedge clk);
            apply(a0 * 37 + a1 * 11 + m0);
            @(negedge clk);
            check_all();
          end

    // R9: change only junk bits; outputs must not move
    @(negedge clk);
    apply(8'h00);
    @(negedge clk);
    apply(8'hE7);
    @(negedge clk);
    check_all();

    // R7: entry 1 in top-of-range; change only entry 0's address
    md[0] = 0; ad[0] = 2; md[1] = 1; ad[1] = 12;
    apply(0);
    @(negedge clk);
    ad[0] = 6;
    apply(0);
    #1;
    chk("R7 before edge", int'(lo_out[1*BW +: BW]), 8);
    @(negedge clk);
    model(1, 12, 6, lo, hi);
    chk("R7 after edge", int'(lo_out[1*BW +: BW]), lo);
    chk("R7 after edge hi", int'(hi_out[1*BW +: BW]), hi);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule